// File: doc/BRIEF.md
# Management Frame Register Engine

This block sits behind a host register bus and stands in for a serial PHY management port. The host writes one 32-bit word into the frame register and that word holds a whole management frame: start code, opcode, PHY address, register address, turnaround and 16 bits of data. In the same clock edge, the block checks the frame, reads or writes an internal 32-entry, 16-bit PHY register file, and stores the word with turnaround bit 16 set to mark completion. The host then reads the frame register back. After a read frame, the data field holds the selected PHY register. No serial shifting takes place.

The PHY register file models the effects of writing the control register. Setting the reset bit turns on auto-negotiation. Setting the restart bit completes auto-negotiation at once and, if the link is up, reports the link and the partner's 100-full ability. A `link_up` input tracks the link. Each change of this input updates the link bits and loads a 16-bit management status word with 0xFFFF. This status drives `mgmt_irq` and is cleared by a read. A config register holds two read-only transceiver-sense bits.

The host bus is a plain register port. No data stream crosses the block's edge, so there is no valid/ready handshake. The block accepts one access per cycle with no back-pressure. Read data is combinational from the addressed register. Write effects are visible from the next cycle. Bus addresses: 0 is the frame register, 1 is the config register, 2 is the management status register.

Top module: `mgmt_frame_engine`

## Requirements
- R1: Every write to the frame register (address 0) stores the written word with bit 16 set. A read of address 0 returns that stored word until the next frame write replaces all of it.
- R2: A frame whose start field [31:30] is not 01, or whose PHY address field [27:23] is not 1, performs no PHY register access. The stored word equals the written word with bit 16 set.
- R3: A valid frame with opcode [29:28] = 01 writes data [15:0] into the PHY register selected by [22:18].
- R4: A valid frame with opcode 10 stores the word with data [15:0] replaced by the selected PHY register's contents.
- R5: A valid frame with opcode 00 or 11 performs no PHY register access and stores the word unchanged except bit 16.
- R6: A write to PHY register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R7: A write to PHY register 0 with bit 9 set stores the value with bit 9 cleared and sets bit 5 of register 1. If `link_up` is high, it also sets bit 2 of register 1 and bit 8 of register 5.
- R8: In the config register (address 1), bits 9:8 ignore host writes and reset to 01. The other bits store what the host writes. The reset value is 0x0000_0100.
- R9: In the cycle after any change of `link_up`, bit 2 of PHY register 1 and bit 8 of PHY register 5 equal the new link state, and the management status register (address 2) reads 0xFFFF.
- R10: `mgmt_irq` is high exactly while the management status register is nonzero. An access with `bus_rd` high to address 2 returns the status and clears it, unless a link change occurs in the same cycle.
- R11: After reset, the frame register and management status read 0 and `mgmt_irq` is low. PHY register 1 reads 0x4008, or 0x400C with the link up. Register 4 reads 0x0100. Register 5 reads 0x0100 with the link up and 0 otherwise. All other PHY registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Current link state from the line side |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (clears status on address 2) |
| bus_addr | input | 2 | Host register select: 0 frame, 1 config, 2 status |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational |
| mgmt_irq | output | 1 | Management interrupt, high while status is nonzero |

## Verification
On every cycle, the assertions check the following:
- the completion bit after each frame write;
- the stored word for rejected frames;
- the PHY register contents after plain register writes;
- the control-register reset rewrite;
- the read-only config bits;
- the status and interrupt after a link change or a clearing read.

Some behaviours only the bench's scenarios can show. These are the read-data substitution against a model of the register file, the restart side effects under both link states, the absence of access across every start/opcode/PHY-address combination, and the reset values under both link states.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 16;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;
  localparam int STAT_W = 16;

  typedef enum logic [1:0] {
    HA_FRAME = 2'd0,
    HA_CFG   = 2'd1,
    HA_MSTAT = 2'd2,
    HA_NONE  = 2'd3
  } host_addr_e;

  typedef struct packed {
    logic [1:0]        st;
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [REG_AW-1:0] ra;
    logic [1:0]        ta;
    logic [DATA_W-1:0] data;
  } frame_t;

  localparam logic [1:0] ST_OK = 2'b01;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam int CTL_IDX  = 0;
  localparam int STAT_IDX = 1;
  localparam int ADV_IDX  = 4;
  localparam int PART_IDX = 5;

  localparam int CTL_RST_BIT     = 15;
  localparam int CTL_ANEN_BIT    = 12;
  localparam int CTL_RESTART_BIT = 9;
  localparam int STAT_ANDONE_BIT = 5;
  localparam int STAT_LINK_BIT   = 2;
  localparam int PART_100FD_BIT  = 8;

  localparam logic [DATA_W-1:0] STAT_BASE = 16'h4008;
  localparam logic [DATA_W-1:0] ADV_RESET = 16'h0100;
endpackage

// File: rtl/mfe_frame_decode.sv
module mfe_frame_decode
  import mfe_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              acc_wr,
  output logic [REG_AW-1:0] acc_ra,
  output logic [DATA_W-1:0] acc_data,
  output logic [WORD_W-1:0] word_out
);
  localparam logic [4:0] PHY_A = 5'(PHY_ADDR);

  frame_t f;
  frame_t stored;
  logic   acc_ok;
  logic   acc_rd;

  always_comb begin
    f      = frame_t'(word_in);
    acc_ok = (f.st == ST_OK) && (f.phy == PHY_A);
    acc_wr = acc_ok && (f.op == OP_WR);
    acc_rd = acc_ok && (f.op == OP_RD);
    acc_ra = f.ra;
    acc_data = f.data;
    stored = f;
    stored.ta[0] = 1'b1;
    if (acc_rd) stored.data = rd_data;
    word_out = stored;
  end
endmodule

// File: rtl/mfe_phy_regs.sv
module mfe_phy_regs
  import mfe_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          link_up,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [REG_AW-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          link_evt,
  output logic [NREGS-1:0][DATA_W-1:0]  regs_q
);
  logic              link_q;
  logic [DATA_W-1:0] store_val;
  logic              restart;

  assign link_evt = (link_q != link_up);
  assign rd_data  = regs_q[rd_addr];

  // Control-register rewrite rules applied before storage
  always_comb begin
    store_val = wr_data;
    restart   = 1'b0;
    if (wr_addr == REG_AW'(CTL_IDX)) begin
      if (store_val[CTL_RST_BIT]) begin
        store_val[CTL_RST_BIT]  = 1'b0;
        store_val[CTL_ANEN_BIT] = 1'b1;
      end
      if (store_val[CTL_RESTART_BIT]) begin
        store_val[CTL_RESTART_BIT] = 1'b0;
        restart = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
      regs_q[STAT_IDX] <= STAT_BASE;
      regs_q[STAT_IDX][STAT_LINK_BIT] <= link_up;
      regs_q[ADV_IDX] <= ADV_RESET;
      regs_q[PART_IDX][PART_100FD_BIT] <= link_up;
      link_q <= link_up;
    end else begin
      if (wr_en) begin
        regs_q[wr_addr] <= store_val;
        if (restart) begin
          regs_q[STAT_IDX][STAT_ANDONE_BIT] <= 1'b1;
          if (link_up) begin
            regs_q[STAT_IDX][STAT_LINK_BIT]  <= 1'b1;
            regs_q[PART_IDX][PART_100FD_BIT] <= 1'b1;
          end
        end
      end
      // A link change wins over a same-cycle frame write on its two bits
      if (link_evt) begin
        regs_q[STAT_IDX][STAT_LINK_BIT]  <= link_up;
        regs_q[PART_IDX][PART_100FD_BIT] <= link_up;
      end
      link_q <= link_up;
    end
  end
endmodule

// File: rtl/mfe_host_regs.sv
module mfe_host_regs
  import mfe_pkg::*;
#(
  parameter logic [WORD_W-1:0] CFG_RESET   = 32'h0000_0100,
  parameter logic [WORD_W-1:0] CFG_RO_MASK = 32'h0000_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] frame_word,
  input  logic              link_evt,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              mgmt_irq,
  output logic [WORD_W-1:0] frame_q,
  output logic [WORD_W-1:0] cfg_q,
  output logic [STAT_W-1:0] mstat_q
);
  host_addr_e sel;
  assign sel = host_addr_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      cfg_q   <= CFG_RESET;
      mstat_q <= '0;
    end else begin
      if (bus_wr && sel == HA_FRAME) frame_q <= frame_word;
      if (bus_wr && sel == HA_CFG)
        cfg_q <= (bus_wdata & ~CFG_RO_MASK) | (cfg_q & CFG_RO_MASK);
      if (link_evt) mstat_q <= '1;
      else if (bus_rd && sel == HA_MSTAT) mstat_q <= '0;
    end
  end

  always_comb begin
    case (sel)
      HA_FRAME: bus_rdata = frame_q;
      HA_CFG:   bus_rdata = cfg_q;
      HA_MSTAT: bus_rdata = {{(WORD_W-STAT_W){1'b0}}, mstat_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign mgmt_irq = |mstat_q;
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mfe_pkg::*;
#(
  parameter int                PHY_ADDR    = 1,
  parameter logic [WORD_W-1:0] CFG_RESET   = 32'h0000_0100,
  parameter logic [WORD_W-1:0] CFG_RO_MASK = 32'h0000_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              mgmt_irq
);
  logic                         acc_wr;
  logic [REG_AW-1:0]            acc_ra;
  logic [DATA_W-1:0]            acc_data;
  logic [DATA_W-1:0]            phy_rd;
  logic [WORD_W-1:0]            frame_word;
  logic                         link_evt;
  logic                         phy_we;
  logic [NREGS-1:0][DATA_W-1:0] phy_q;
  logic [WORD_W-1:0]            frame_q;
  logic [WORD_W-1:0]            cfg_q;
  logic [STAT_W-1:0]            mstat_q;

  assign phy_we = bus_wr && (bus_addr == 2'(HA_FRAME)) && acc_wr;

  mfe_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .word_in  (bus_wdata),
    .rd_data  (phy_rd),
    .acc_wr   (acc_wr),
    .acc_ra   (acc_ra),
    .acc_data (acc_data),
    .word_out (frame_word)
  );

  mfe_phy_regs u_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_up  (link_up),
    .wr_en    (phy_we),
    .wr_addr  (acc_ra),
    .wr_data  (acc_data),
    .rd_addr  (acc_ra),
    .rd_data  (phy_rd),
    .link_evt (link_evt),
    .regs_q   (phy_q)
  );

  mfe_host_regs #(.CFG_RESET(CFG_RESET), .CFG_RO_MASK(CFG_RO_MASK)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .frame_word (frame_word),
    .link_evt   (link_evt),
    .bus_rdata  (bus_rdata),
    .mgmt_irq   (mgmt_irq),
    .frame_q    (frame_q),
    .cfg_q      (cfg_q),
    .mstat_q    (mstat_q)
  );
endmodule

// File: rtl/mfe_checker.sv
module mfe_checker
  import mfe_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic                         bus_rd,
  input logic [1:0]                   bus_addr,
  input logic [WORD_W-1:0]            bus_wdata,
  input logic                         link_evt,
  input logic                         mgmt_irq,
  input logic [WORD_W-1:0]            frame_q,
  input logic [WORD_W-1:0]            cfg_q,
  input logic [STAT_W-1:0]            mstat_q,
  input logic [NREGS-1:0][DATA_W-1:0] phy_q
);
  localparam logic [4:0] PHY_A = 5'(PHY_ADDR);

  logic fw, good;
  assign fw   = bus_wr && (bus_addr == 2'd0);
  assign good = (bus_wdata[31:30] == ST_OK) && (bus_wdata[27:23] == PHY_A);

  a_r1_ta_set: assert property (@(posedge clk) disable iff (!rst_n)
    fw |=> frame_q[16]);

  a_r2_bad_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (fw && !good) |=> frame_q == ($past(bus_wdata) | 32'h0001_0000));

  a_r3_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fw && good && bus_wdata[29:28] == OP_WR && bus_wdata[22:18] >= 5'd2
     && bus_wdata[22:18] != 5'(PART_IDX))
    |=> phy_q[$past(bus_wdata[22:18])] == $past(bus_wdata[15:0]));

  a_r6_ctl_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (fw && good && bus_wdata[29:28] == OP_WR && bus_wdata[22:18] == 5'd0
     && bus_wdata[15])
    |=> (!phy_q[CTL_IDX][CTL_RST_BIT] && phy_q[CTL_IDX][CTL_ANEN_BIT]));

  a_r8_cfg_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> cfg_q[9:8] == $past(cfg_q[9:8]));

  a_r9_link_change: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> (mstat_q == 16'hFFFF && mgmt_irq));

  a_r10_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2 && !link_evt) |=> (mstat_q == '0 && !mgmt_irq));
endmodule

bind mgmt_frame_engine mfe_checker #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .link_evt  (link_evt),
  .mgmt_irq  (mgmt_irq),
  .frame_q   (frame_q),
  .cfg_q     (cfg_q),
  .mstat_q   (mstat_q),
  .phy_q     (phy_q)
);

// File: tb/mgmt_frame_engine_test.sv
module mgmt_frame_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mgmt_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] mdl [32];
  logic        mdl_link;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mgmt_irq(mgmt_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, input bit clr, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = clr;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic mdl_reset(input logic lk);
    for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
    mdl[1] = lk ? 16'h400C : 16'h4008;
    mdl[4] = 16'h0100;
    mdl[5] = lk ? 16'h0100 : 16'h0000;
    mdl_link = lk;
  endtask

  task automatic do_reset(input logic lk);
    @(negedge clk);
    rst_n = 1'b0; link_up = lk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdl_reset(lk);
  endtask

  task automatic frame(input string req, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] w, e, v;
    logic [15:0] nv;
    w = {st, op, phy, ra, 2'b00, d};
    e = w | 32'h0001_0000;
    if (st == 2'b01 && phy == 5'd1) begin
      if (op == 2'b10) e[15:0] = mdl[ra];
      else if (op == 2'b01) begin
        nv = d;
        if (ra == 5'd0) begin
          if (nv[15]) begin nv[15] = 1'b0; nv[12] = 1'b1; end
          if (nv[9]) begin
            nv[9] = 1'b0;
            mdl[1][5] = 1'b1;
            if (mdl_link) begin mdl[1][2] = 1'b1; mdl[5][8] = 1'b1; end
          end
        end
        mdl[ra] = nv;
      end
    end
    host_wr(2'd0, w);
    host_rd(2'd0, 1'b0, v);
    chk(req, v, e);
  endtask

  task automatic peek(input string req, input logic [4:0] ra);
    frame(req, 2'b01, 2'b10, 5'd1, ra, 16'h0);
  endtask

  task automatic set_link(input logic lv);
    logic [31:0] v;
    @(negedge clk);
    link_up = lv;
    @(negedge clk);
    mdl_link = lv; mdl[1][2] = lv; mdl[5][8] = lv;
    chk("R10 irq after link change", {31'b0, mgmt_irq}, 32'h1);
    host_rd(2'd2, 1'b1, v);
    chk("R9 status after link change", v, 32'h0000_FFFF);
    host_rd(2'd2, 1'b0, v);
    chk("R10 status cleared by read", v, 32'h0);
    chk("R10 irq low after clear", {31'b0, mgmt_irq}, 32'h0);
    peek("R9 link bit in reg1", 5'd1);
    peek("R9 partner bit in reg5", 5'd5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset(1'b1);
    // R11 reset state with link up
    host_rd(2'd0, 1'b0, v); chk("R11 frame reset", v, 32'h0);
    host_rd(2'd1, 1'b0, v); chk("R8 config reset", v, 32'h0000_0100);
    host_rd(2'd2, 1'b0, v); chk("R11 status reset", v, 32'h0);
    chk("R11 irq reset", {31'b0, mgmt_irq}, 32'h0);
    for (int r = 0; r < 32; r++) peek("R11 reset reg, R4 read", 5'(r));

    // R3 write sweep over registers 2..31, then R4 readback
    for (int r = 2; r < 32; r++)
      frame("R3 write sweep", 2'b01, 2'b01, 5'd1, 5'(r), 16'(r * 16'h0101) ^ 16'h5A3C);
    for (int r = 0; r < 32; r++) peek("R4 readback sweep", 5'(r));

    // R1/R2/R5 start x opcode sweep on register 7
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin
        frame("R1 R2 R5 start/opcode sweep", 2'(s), 2'(o), 5'd1, 5'd7, 16'(16'h1000 + s * 16 + o));
        peek("R2 R5 reg7 after sweep frame", 5'd7);
      end

    // R2 PHY address sweep on register 9
    for (int p = 0; p < 32; p++) begin
      frame("R2 phy address sweep", 2'b01, 2'b01, 5'(p), 5'd9, 16'(16'hC000 | p));
      peek("R2 reg9 after phy sweep", 5'd9);
    end

    // R6 control reset bit
    frame("R6 ctl reset write", 2'b01, 2'b01, 5'd1, 5'd0, 16'h8000);
    peek("R6 ctl readback", 5'd0);
    // R7 restart with link up
    frame("R7 clear reg1", 2'b01, 2'b01, 5'd1, 5'd1, 16'h4008);
    frame("R7 clear reg5", 2'b01, 2'b01, 5'd1, 5'd5, 16'h0000);
    frame("R7 restart link up", 2'b01, 2'b01, 5'd1, 5'd0, 16'h8240);
    peek("R7 ctl after restart", 5'd0);
    peek("R7 reg1 after restart up", 5'd1);
    peek("R7 reg5 after restart up", 5'd5);

    // R9 link down, then R7 restart with link down
    set_link(1'b0);
    frame("R7 clear reg1 again", 2'b01, 2'b01, 5'd1, 5'd1, 16'h4008);
    frame("R7 restart link down", 2'b01, 2'b01, 5'd1, 5'd0, 16'h0200);
    peek("R7 reg1 after restart down", 5'd1);
    peek("R7 reg5 after restart down", 5'd5);
    set_link(1'b1);

    // R8 config read-only bits
    host_wr(2'd1, 32'hFFFF_FFFF);
    host_rd(2'd1, 1'b0, v); chk("R8 config all ones", v, 32'hFFFF_FDFF);
    host_wr(2'd1, 32'h0000_0000);
    host_rd(2'd1, 1'b0, v); chk("R8 config zero", v, 32'h0000_0100);

    // R11 reset with link down
    do_reset(1'b0);
    peek("R11 reg1 link down", 5'd1);
    peek("R11 reg5 link down", 5'd5);
    peek("R11 reg4 link down", 5'd4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule